// File: doc/BRIEF.md
# Bridge Deadlock Breaker

This block watches the two arbitration paths of a bridge between a local processor bus and a PCI-style bus. A deadlock exists when two cycles are blocked at once. The first is an outbound cycle, from the local side to the PCI side, that is pending while the bridge does not hold the PCI bus. The second is an inbound cycle, from the PCI side to the local side, that is pending while the bridge does not hold the local bus. Each side then waits for the other and neither can finish.

While a deadlock lasts, two independent timers count the same clocks. The release timer ends in a one-clock request that tells the local master to give up its bus and retry later, so the inbound cycle can complete. The retry timer ends in a one-clock strobe that tells the PCI-side requester to terminate with retry, so the outbound cycle can complete. Whichever timer is programmed shorter decides which side yields. Clearing the release enable gives a mode in which the local master is never preempted. In that mode only inbound cycles are retried, so a PCI read is never issued and then thrown away. Both outputs are plain control pulses. The block carries no data stream, so it has no valid/ready interface and no back-pressure.

Top module: `bdl_breaker`

## Requirements
- R1: Deadlock is the AND of four terms: `ob_pend` high, `ob_own` low, `ib_pend` high and `ib_own` low, all in the same clock. The block never pulses an output unless deadlock held at the previous clock edge. With any one term missing, no output ever pulses.
- R2: Let the release timer be armed, meaning `rel_en` = 1 and `rel_dly` = N, where N is not 0. Deadlock starts just after a rising edge and holds. `lcl_release` is then high during the clock that follows the (8·N)-th rising edge, provided the retry timer has not fired earlier.
- R3: Let `rty_dly` = M, where M is not 0. Under the same conditions, `pci_retry` is high during the clock that follows the (8·M)-th rising edge of deadlock, provided the release timer has not fired at or before that edge.
- R4: A delay field value of 0 disables that timer, so its output never pulses.
- R5: With `rel_en` = 0, `lcl_release` never pulses whatever `rel_dly` holds, and only the retry timer can end a deadlock.
- R6: When both timers expire on the same edge, only `lcl_release` pulses. `pci_retry` stays low in that clock and afterwards.
- R7: Each clock in which deadlock is false clears both counts to zero. A deadlock that is broken and then resumes needs the full programmed delay again.
- R8: At most one output pulse is produced per deadlock episode. After deadlock has been false for at least one clock, the block can fire again.
- R9: Each output pulse lasts exactly one clock.
- R10: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ob_pend | input | 1 | Outbound (local to PCI) cycle pending |
| ob_own | input | 1 | Bridge currently owns the PCI bus |
| ib_pend | input | 1 | Inbound (PCI to local) cycle pending |
| ib_own | input | 1 | Bridge currently owns the local bus |
| rel_dly | input | DLY_W (4) | Release delay in units of UNIT (8) clocks; 0 disables |
| rel_en | input | 1 | Arms the release timer |
| rty_dly | input | DLY_W (4) | Retry delay in units of UNIT (8) clocks; 0 disables |
| lcl_release | output | 1 | One-clock request for the local master to relinquish the bus |
| pci_retry | output | 1 | One-clock strobe to retry the PCI-side requester |

## Verification
The assertions check on every clock the rules that hold at all times. The outputs are never high together, each pulse lasts one clock, no pulse appears without a deadlock at the previous edge, a disabled release timer stays silent, and the counters stay in range and stop once a timer has fired. Only the bench can show that a pulse arrives at exactly the edge that matches the programmed delay. The bench also shows how the two fields and the enable decide which side yields, and that a broken deadlock restarts the full count. For this it sweeps every value of the two fields with both enable settings and predicts each pulse's edge arithmetically.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
  parameter int unsigned DLY_W_DEF = 4;
  parameter int unsigned UNIT_DEF  = 8;

  // Width able to hold the largest terminal count (max field * unit)
  function automatic int unsigned cnt_width(int unsigned dw, int unsigned unit);
    return $clog2(((1 << dw) - 1) * unit + 1);
  endfunction
endpackage

// File: rtl/bdl_timer.sv
module bdl_timer #(
  parameter int unsigned DLY_W = 4,
  parameter int unsigned UNIT  = 8,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             arm,
  input  logic [DLY_W-1:0] dly,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             armed;

  assign limit  = CNT_W'(dly) * CNT_W'(UNIT);
  assign armed  = arm && (dly != '0);
  assign expire = run && armed && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
  end

  // after expiry the parent must stop the run for the rest of the episode
  p_stop_after_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !run);
  // an idle clock leaves the counter at zero
  p_clear_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/bdl_breaker.sv
module bdl_breaker
  import bdl_pkg::*;
#(
  parameter int unsigned DLY_W = DLY_W_DEF,
  parameter int unsigned UNIT  = UNIT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ob_pend,
  input  logic             ob_own,
  input  logic             ib_pend,
  input  logic             ib_own,
  input  logic [DLY_W-1:0] rel_dly,
  input  logic             rel_en,
  input  logic [DLY_W-1:0] rty_dly,
  output logic             lcl_release,
  output logic             pci_retry
);
  localparam int unsigned CNT_W = cnt_width(DLY_W, UNIT);

  logic deadlock;
  logic fired;
  logic run;
  logic rel_exp;
  logic rty_exp;

  assign deadlock = ob_pend && !ob_own && ib_pend && !ib_own;
  assign run      = deadlock && !fired;

  bdl_timer #(.DLY_W(DLY_W), .UNIT(UNIT), .CNT_W(CNT_W)) u_rel (
    .clk(clk), .rst_n(rst_n), .run(run), .arm(rel_en),
    .dly(rel_dly), .expire(rel_exp)
  );

  bdl_timer #(.DLY_W(DLY_W), .UNIT(UNIT), .CNT_W(CNT_W)) u_rty (
    .clk(clk), .rst_n(rst_n), .run(run), .arm(1'b1),
    .dly(rty_dly), .expire(rty_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcl_release <= 1'b0;
      pci_retry   <= 1'b0;
      fired       <= 1'b0;
    end else begin
      lcl_release <= rel_exp;
      pci_retry   <= rty_exp && !rel_exp;   // release wins a tie
      fired       <= deadlock && (fired || rel_exp || rty_exp);
    end
  end

  p_no_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lcl_release && pci_retry));
  p_rel_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_release |=> !lcl_release);
  p_rty_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pci_retry |=> !pci_retry);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_release || pci_retry) |-> $past(deadlock));
  p_rel_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_release |-> $past(rel_en));
  p_reset_low_r10: assert property (@(posedge clk)
    !rst_n |=> (!lcl_release && !pci_retry));
endmodule

// File: tb/bdl_breaker_test.sv
module bdl_breaker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ob_pend = 1'b0, ob_own = 1'b0, ib_pend = 1'b0, ib_own = 1'b0;
  logic [3:0] rel_dly = 4'd0, rty_dly = 4'd0;
  logic       rel_en = 1'b0;
  logic       lcl_release, pci_retry;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;  // 125 MHz

  bdl_breaker uut (
    .clk(clk), .rst_n(rst_n), .ob_pend(ob_pend), .ob_own(ob_own),
    .ib_pend(ib_pend), .ib_own(ib_own), .rel_dly(rel_dly), .rel_en(rel_en),
    .rty_dly(rty_dly), .lcl_release(lcl_release), .pci_retry(pci_retry)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic set_dl(input bit a, input bit b, input bit c, input bit d);
    ob_pend = a; ob_own = b; ib_pend = c; ib_own = d;
  endtask

  // Hold the given bus state for `len` edges, return pulse count and edge of first pulse
  task automatic observe(input int len, output int rc, output int rk,
                         output int tc, output int tk);
    rc = 0; rk = 0; tc = 0; tk = 0;
    for (int k = 1; k <= len; k++) begin
      @(posedge clk); @(negedge clk);
      if (lcl_release) begin rc++; if (rk == 0) rk = k; end
      if (pci_retry)   begin tc++; if (tk == 0) tk = k; end
    end
  endtask

  task automatic idle(input int n);
    set_dl(0, 0, 0, 0);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int rc, rk, tc, tk;
    @(negedge clk);
    // R10: reset state
    observe(3, rc, rk, tc, tk);
    chk(rc == 0 && tc == 0, "R10 outputs low in reset", rc + tc, 0);
    rst_n = 1'b1;

    // R1: each missing deadlock term keeps the block silent
    rel_en = 1; rel_dly = 4'd1; rty_dly = 4'd1;
    for (int m = 0; m < 4; m++) begin
      set_dl(m != 0, m == 1, m != 2, m == 3);
      observe(20, rc, rk, tc, tk);
      chk(rc == 0 && tc == 0, "R1 partial condition no pulse", rc + tc, 0);
      idle(2);
    end

    // R2-R6, R8, R9: full sweep of both fields and the enable
    for (int en = 0; en < 2; en++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          int tr, tt, er, et;
          rel_en = en[0]; rel_dly = a[3:0]; rty_dly = b[3:0];
          tr = (en == 1 && a != 0) ? a * 8 : 1000;
          tt = (b != 0) ? b * 8 : 1000;
          er = 0; et = 0;
          if (tr <= tt && tr < 1000) er = tr;
          else if (tt < 1000) et = tt;
          set_dl(1, 0, 1, 0);
          observe(128, rc, rk, tc, tk);
          chk(rc == (er != 0 ? 1 : 0) && rk == er,
              "R2/R5/R6/R8/R9 lcl_release edge", rk * 10 + rc, er * 10 + (er != 0 ? 1 : 0));
          chk(tc == (et != 0 ? 1 : 0) && tk == et,
              "R3/R4/R6/R8/R9 pci_retry edge", tk * 10 + tc, et * 10 + (et != 0 ? 1 : 0));
          idle(1);
        end

    // R7: broken deadlock restarts the full count (release 4 -> 32 edges)
    rel_en = 1; rel_dly = 4'd4; rty_dly = 4'd0;
    set_dl(1, 0, 1, 0);
    observe(20, rc, rk, tc, tk);
    chk(rc == 0, "R7 no pulse before break", rc, 0);
    set_dl(1, 1, 1, 0);          // bridge wins PCI bus for one clock
    observe(1, rc, rk, tc, tk);
    set_dl(1, 0, 1, 0);
    observe(40, rc, rk, tc, tk);
    chk(rc == 1 && rk == 32, "R7 full delay after restart", rk, 32);

    // R8: fires again in a later episode
    idle(1);
    set_dl(1, 0, 1, 0);
    observe(40, rc, rk, tc, tk);
    chk(rc == 1 && rk == 32, "R8 second episode fires", rk, 32);
    idle(2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule